// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a single-rank SDRAM refreshed on a fixed clock-count interval. A 12-bit interval counter advances on every controller clock. When it matches a limit that software has programmed, the block raises a refresh request towards the controller's access arbiter. Once the arbiter grants the bus and no data burst is still in flight, the block drives a fixed command train on the SDRAM control pins. That train is a precharge of every bank, a programmable precharge wait, an auto-refresh, and a programmable row-cycle wait. It then hands the bus back.

The limit has to be chosen with a margin below the raw refresh interval of the memory. This covers the time a burst already under way may still need before the refresh can start. An indication that self-refresh is being entered restarts the interval from zero. A limit of zero switches refresh requests off. The block does not handle read and write sequencing, power-up initialisation, self-refresh entry and exit, or mode-register programming.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With a non-zero limit L and no self-refresh indication, the request rises L+1 clock cycles after reset release or after the previous expiry, and the counter restarts from zero at each expiry. The counter wraps modulo 4096.
- R2: While the limit is zero, the request never rises.
- R3: A cycle with `self_ref_enter` high clears the interval counter and produces no expiry in that cycle.
- R4: Once raised, the request stays high until a sequence starts. Further expiries while it is pending start no additional sequence.
- R5: A sequence starts on a clock edge only when `req`, `grant` and not `burst_busy` are all high and no sequence is running. `busy` goes high on the following cycle.
- R6: The sequence is one precharge-all cycle with `a10` high, then tRP NOP cycles, one auto-refresh cycle, then tRC NOP cycles. `a10` is low in every other cycle.
- R7: `busy` is high from the precharge-all cycle through the last tRC NOP cycle, and low otherwise. The arbiter is expected to keep the bus granted while `busy` is high.
- R8: Commands are encoded as {cs_n, ras_n, cas_n, we_n}: NOP = 0111, precharge-all = 0010, auto-refresh = 0001. NOP is driven whenever no other command is issued, including during reset.
- R9: `cke` is high at all times, and in particular throughout the sequence.
- R10: A tRP or tRC setting of 0 is treated as 1. The values 1 to 15 give exactly that many NOP cycles.
- R11: If an expiry falls on the same edge as a sequence start, the request stays high for the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| limit | input | 12 | Programmed refresh interval in clocks; 0 disables requests |
| trp | input | 4 | Precharge wait in cycles |
| trc | input | 4 | Row-cycle wait after auto-refresh in cycles |
| self_ref_enter | input | 1 | Self-refresh entry indication, clears the counter |
| grant | input | 1 | Bus grant from the arbiter |
| burst_busy | input | 1 | A data burst is still in progress |
| req | output | 1 | Refresh request to the arbiter |
| busy | output | 1 | Block owns the SDRAM command bus |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, high selects all banks on precharge |

## Verification
The assertions assume three things about the inputs. First, `trp` and `trc` do not change while a sequence runs. Second, the arbiter keeps the grant during `busy`. Third, `self_ref_enter` is a plain level sampled on each edge. The stimulus only redraws `trp` and `trc` on cycles in which the bench's own model shows the block idle. It draws `grant`, `burst_busy` and rare self-refresh pulses at random. The limit is changed at random moments across small values and zero. This reaches expiries that fall during a sequence and expiries that fall on its start edge.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CW = 12,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] limit,
  input  logic [TW-1:0] trp,
  input  logic [TW-1:0] trc,
  input  logic          self_ref_enter,
  input  logic          grant,
  input  logic          burst_busy,
  output logic          req,
  output logic          busy,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          a10
);

  localparam logic [3:0]    CMD_NOP  = 4'b0111;
  localparam logic [3:0]    CMD_PALL = 4'b0010;
  localparam logic [3:0]    CMD_AREF = 4'b0001;
  localparam logic [TW-1:0] T_ONE    = {{(TW-1){1'b0}}, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_PALL, S_WRP, S_AREF, S_WRC} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;

  wire expire = !self_ref_enter && (limit != '0) && (cnt == limit);
  wire start  = req && grant && !burst_busy && (st == S_IDLE);
  wire [TW-1:0] rp_eff = (trp == '0) ? T_ONE : trp;
  wire [TW-1:0] rc_eff = (trc == '0) ? T_ONE : trc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      req <= 1'b0;
    end else begin
      cnt <= (self_ref_enter || expire) ? '0 : cnt + 1'b1;
      if (expire)     req <= 1'b1;
      else if (start) req <= 1'b0;
    end
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (start) st_nx = S_PALL;
      S_PALL: st_nx = S_WRP;
      S_WRP:  if (tmr == '0) st_nx = S_AREF;
      S_AREF: st_nx = S_WRC;
      S_WRC:  if (tmr == '0) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      tmr <= '0;
    end else begin
      st <= st_nx;
      case (st)
        S_PALL:         tmr <= rp_eff - T_ONE;
        S_AREF:         tmr <= rc_eff - T_ONE;
        S_WRP, S_WRC:   tmr <= (tmr == '0) ? '0 : tmr - T_ONE;
        default:        tmr <= '0;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = (st == S_PALL) ? CMD_PALL :
                                      (st == S_AREF) ? CMD_AREF : CMD_NOP;
  assign a10  = (st == S_PALL);
  assign busy = (st != S_IDLE);
  assign cke  = 1'b1;

endmodule

module sdram_refresh_sched_chk #(
  parameter int CW = 12,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] limit,
  input logic          self_ref_enter,
  input logic          grant,
  input logic          burst_busy,
  input logic          req,
  input logic          busy,
  input logic          cke,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          a10
);
  wire is_nop  = !cs_n &&  ras_n &&  cas_n &&  we_n;
  wire is_pall = !cs_n && !ras_n &&  cas_n && !we_n;
  wire is_aref = !cs_n && !ras_n && !cas_n &&  we_n;

  a_r2_zero_limit_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(limit) != '0);
  a_r3_selfref_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> !$past(self_ref_enter));
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !(grant && !burst_busy && !busy)) |=> req);
  a_r5_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req && grant && !burst_busy));
  a_r6_starts_with_pall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> is_pall);
  a_r6_pall_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
    is_pall |=> is_nop);
  a_r6_aref_after_nop: assert property (@(posedge clk) disable iff (!rst_n)
    is_aref |-> $past(is_nop) && busy);
  a_r6_a10_only_pall: assert property (@(posedge clk) disable iff (!rst_n)
    a10 |-> is_pall);
  a_r7_wait_after_aref: assert property (@(posedge clk) disable iff (!rst_n)
    is_aref |=> busy && is_nop);
  a_r8_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop || is_pall || is_aref);
  a_r9_cke_high: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cke);
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .limit(limit), .self_ref_enter(self_ref_enter),
  .grant(grant), .burst_busy(burst_busy), .req(req), .busy(busy), .cke(cke),
  .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10)
);

// File: tb/sdram_refresh_sched_test.sv
module sdram_refresh_sched_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] limit = 12'd5;
  logic [3:0]  trp = 4'd2, trc = 4'd3;
  logic        self_ref_enter = 1'b0, grant = 1'b0, burst_busy = 1'b0;
  logic        req, busy, cke, cs_n, ras_n, cas_n, we_n, a10;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .limit(limit), .trp(trp), .trc(trc),
    .self_ref_enter(self_ref_enter), .grant(grant), .burst_busy(burst_busy),
    .req(req), .busy(busy), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10)
  );

  int n_chk = 0, n_fail = 0;
  bit model_on = 0;
  int m_cnt = 0, m_pos = 0, m_rp = 1, m_rc = 1;
  bit m_pend = 0;

  function automatic int eff(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  // R8 encodings {cs_n,ras_n,cas_n,we_n}: NOP 0111, PALL 0010, AREF 0001
  function automatic int exp_cmd(input int pos, input int rp);
    if (pos == 1) return 4'b0010;
    if (pos == rp + 2) return 4'b0001;
    return 4'b0111;
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pend = 0; m_pos = 0;
    end else begin
      bit st, ex;
      st = m_pend && grant && !burst_busy && (m_pos == 0);
      ex = !self_ref_enter && (limit != 0) && (m_cnt == int'(limit));
      if (m_pos != 0) m_pos = (m_pos == m_rp + m_rc + 2) ? 0 : m_pos + 1;
      else if (st) begin
        m_pos = 1; m_rp = eff(trp); m_rc = eff(trc);
      end
      m_cnt = (self_ref_enter || ex) ? 0 : (m_cnt + 1) % 4096;
      m_pend = ex ? 1'b1 : (st ? 1'b0 : m_pend);
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R1/R4/R11 req", req, m_pend);
      check("R6/R8 cmd", {cs_n, ras_n, cas_n, we_n}, exp_cmd(m_pos, m_rp));
      check("R7 busy", busy, m_pos != 0);
      check("R6 a10", a10, m_pos == 1);
      check("R9 cke", cke, 1);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int k, rises, palls, t0;
    bit prev;
    void'($urandom(32'd20240611));
    tick(3);
    // R8 reset state
    check("R8 reset cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    check("R8 reset req", req, 0);
    check("R7 reset busy", busy, 0);
    rst_n = 1'b1;
    model_on = 1;

    // R1: limit 5 -> request after 6 cycles
    k = 0;
    while (!req && k < 50) begin tick(1); k++; end
    check("R1 first period", k, 6);

    // R10: zero waits act as one
    trp = 4'd0; trc = 4'd0;
    grant = 1'b1;
    k = 0;
    while (!a10 && k < 50) begin tick(1); k++; end
    t0 = 0;
    while (!(!cas_n && !ras_n) && t0 < 20) begin tick(1); t0++; end
    check("R10 pall to aref", t0, 2);
    tick(1); check("R10 trc of one", busy, 1);
    tick(1); check("R10 released", busy, 0);

    // R2: zero limit never requests
    limit = 12'd0;
    tick(40);
    rises = 0; prev = req;
    for (int i = 0; i < 5000; i++) begin
      tick(1);
      if (req && !prev) rises++;
      prev = req;
    end
    check("R2 no request", rises, 0);
    check("R2 req low", req, 0);

    // R3: self-refresh keeps clearing the counter
    grant = 1'b0; limit = 12'd8;
    rises = 0;
    for (int i = 0; i < 100; i++) begin
      self_ref_enter = (i % 4 == 0);
      tick(1);
      if (req) rises++;
    end
    self_ref_enter = 1'b0;
    check("R3 no request", rises, 0);

    // R4: held request, one sequence only
    trp = 4'd1; trc = 4'd1;
    tick(60);
    check("R4 req held", req, 1);
    check("R4 no sequence", busy, 0);
    burst_busy = 1'b1; grant = 1'b1;
    k = 0;
    for (int i = 0; i < 30; i++) begin tick(1); if (busy) k++; end
    check("R5 blocked by burst", k, 0);
    burst_busy = 1'b0;
    tick(1);
    check("R5 starts after burst", busy, 1);
    grant = 1'b0;
    palls = 1;
    for (int i = 0; i < 7; i++) begin tick(1); if (a10) palls++; end
    check("R4 single sequence", palls, 1);

    // random phase, R11 via expiries landing on start edges
    limit = 12'd1;
    for (int i = 0; i < 20000; i++) begin
      grant = ($urandom % 4) != 0;
      burst_busy = ($urandom % 3) == 0;
      self_ref_enter = ($urandom % 50) == 0;
      if ($urandom % 500 == 0)
        limit = ($urandom % 8 == 0) ? 12'd0 : 12'(1 + $urandom % 40);
      if (m_pos == 0 && $urandom % 20 == 0) begin
        trp = 4'($urandom % 16);
        trc = 4'($urandom % 16);
      end
      tick(1);
    end
    self_ref_enter = 1'b0;
    tick(2);
    finish_run();
  end
endmodule